// File: doc/BRIEF.md
# Strobe-Framed Serial PCM Port

This block moves one byte of voice data in each direction per frame between a codec-side parallel interface and a line-side serial transceiver. The serial side is a bit clock, an active-high strobe and a pair of data lines. The strobe marks one 8-bit window, and the same window carries both directions. Inside the window the port drives a transmit byte out, one bit per bit-clock rising edge and most significant bit first. It also samples the data input on each bit-clock falling edge, again most significant bit first. Outside the window the serial output is released: its output-enable is low and the pad is left three-stated.

The serial pins arrive asynchronously. A chain of flip-flops in the block's system clock domain resynchronises them, and the bit-clock edges are found by comparing successive synchronised samples. The strobe and the data line pass through synchronisers of the same depth as the bit clock, so their alignment to the bit clock is kept. The parallel side writes the next transmit byte with a one-cycle load strobe. It receives each completed byte together with a one-cycle valid pulse.

The transmit byte is taken into the shifter when a window opens. A byte written while a window is open therefore goes out in the following frame. A window that closes before eight bits have been sampled yields nothing.

Top module: `pcm_strobe_port`

## Requirements
- R1: After reset, `pcm_dout_oe`, `pcm_dout` and `rx_valid` are 0 and `rx_byte` is all zeros.
- R2: `pcm_dout_oe` goes high at the first bit-clock rising edge that sees the strobe high. It falls at the first rising edge that sees the strobe low. While it is low, `pcm_dout` is 0.
- R3: In a window, the bit at position 7-k of the transmit byte (k = 0 for the first bit) is presented on `pcm_dout` after the k-th rising edge of the window. `pcm_dout` changes only after a bit-clock rising edge.
- R4: The byte last written through `tx_load`/`tx_byte` is captured when a window opens. A write made during an open window does not affect that window and is sent in the next one.
- R5: The data input is sampled on bit-clock falling edges inside the window. The first sample becomes bit 7 of `rx_byte`.
- R6: After the eighth sample of a window, `rx_byte` is updated and `rx_valid` is high for exactly one system clock cycle. `rx_byte` changes in no other cycle.
- R7: If the window closes after fewer than eight samples, no valid pulse is raised and `rx_byte` keeps its previous value. The partial byte does not disturb the next frame.
- R8: In a window longer than eight bits, samples after the eighth are ignored and give no further pulse. `pcm_dout` is 0 for every bit after the eighth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous to `clk` |
| strobe_in | input | 1 | Active-high timeslot strobe |
| din_in | input | 1 | Serial receive data |
| tx_byte | input | WORD_W | Parallel transmit byte |
| tx_load | input | 1 | One-cycle write of `tx_byte` into the transmit holding register |
| pcm_dout | output | 1 | Serial transmit data |
| pcm_dout_oe | output | 1 | Pad drive enable for `pcm_dout`; high only inside the window |
| rx_byte | output | WORD_W | Last complete received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |

## Verification
The bench builds the block with its defaults: an 8-bit word and a two-stage synchroniser. It runs the bit clock at one sixteenth of the system clock, which leaves each bit-clock phase eight system cycles long. That ratio absorbs the three-cycle path through synchroniser and edge detector, so every transmitted bit can be checked mid-phase and every receive pulse is counted inside its own frame. With these values the bench covers short, exact and long windows, together with a write made inside an open window.

// File: rtl/pcm_port_pkg.sv
// Package: shared types for the strobe-framed serial PCM port.
// Assumes: nothing; holds the slot state encoding used by the shifters.
package pcm_port_pkg;

    // Whether the shared transmit/receive timeslot is currently open.
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_OPEN = 1'b1
    } slot_e;

endpackage

// File: rtl/pcm_sync.sv
// Module: pcm_sync
// Multi-bit flip-flop synchroniser. Each bit passes through STAGES registers.
// Assumes: the bits are independent level signals that need identical delay;
// all of them see the same number of stages so their relative timing holds.
module pcm_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture of the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Purpose: further settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pcm_edge.sv
// Module: pcm_edge
// Finds rising and falling transitions of a synchronised level signal and
// reports each one as a single-cycle pulse.
// Assumes: the input is already synchronous to clk.
module pcm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic level_q;

    // Purpose: remember the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;

endmodule

// File: rtl/pcm_tx_shift.sv
// Module: pcm_tx_shift
// Transmit half of the port. Holds the next byte written from the parallel
// side. Opens the slot on a bit-clock rising edge that sees the strobe high,
// captures the held byte at that moment and shifts it out MSB first, one bit
// per rising edge. Closes the slot on the first rising edge with the strobe low.
// Assumes: bit_rise is a one-cycle pulse; strobe is aligned to it.
module pcm_tx_shift
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise,
    input  logic              strobe,
    input  logic [WORD_W-1:0] load_byte,
    input  logic              load_en,
    output logic              ser_out,
    output logic              slot_open
);

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] shift_q;
    logic              out_q;
    slot_e             state_q;

    // Purpose: parallel-side holding register for the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (load_en) hold_q <= load_byte;
    end

    // Purpose: slot open/close and MSB-first serialisation on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            shift_q <= '0;
            out_q   <= 1'b0;
        end else if (bit_rise) begin
            if (strobe) begin
                if (state_q == SLOT_IDLE) begin
                    state_q <= SLOT_OPEN;
                    out_q   <= hold_q[WORD_W-1];
                    shift_q <= hold_q << 1;
                end else begin
                    out_q   <= shift_q[WORD_W-1];
                    shift_q <= shift_q << 1;
                end
            end else begin
                state_q <= SLOT_IDLE;
                out_q   <= 1'b0;
                shift_q <= '0;
            end
        end
    end

    assign ser_out   = out_q;
    assign slot_open = (state_q == SLOT_OPEN);

endmodule

// File: rtl/pcm_rx_shift.sv
// Module: pcm_rx_shift
// Receive half of the port. Samples the data line on bit-clock falling edges
// while the slot is open, MSB first. On the last sample of a word it moves
// the word to the output register and pulses valid for one cycle. Samples
// after a full word are ignored; a closed slot discards any partial word.
// Assumes: bit_fall is a one-cycle pulse; din is aligned to it.
module pcm_rx_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_fall,
    input  logic              slot_open,
    input  logic              din,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              valid_q;
    logic              take;
    logic [WORD_W-1:0] shift_nxt;

    assign take      = bit_fall && slot_open && (cnt_q != FULL);
    assign shift_nxt = {shift_q[WORD_W-2:0], din};

    // Purpose: sample counting and shifting; cleared whenever the slot is shut.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (!slot_open) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (take) begin
            cnt_q   <= cnt_q + 1'b1;
            shift_q <= shift_nxt;
        end
    end

    // Purpose: publish a completed word with a one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (take && (cnt_q == LAST)) begin
                word_q  <= shift_nxt;
                valid_q <= 1'b1;
            end
        end
    end

    assign word_out   = word_q;
    assign word_valid = valid_q;

endmodule

// File: rtl/pcm_strobe_port.sv
// Module: pcm_strobe_port (top)
// Strobe-framed serial PCM port. Synchronises bit clock, strobe and data,
// finds bit-clock edges, and runs the transmit and receive shifters over one
// shared strobed timeslot per frame.
// Assumes: the bit clock is slower than clk by enough margin that each of its
// phases spans more than SYNC_STAGES+1 system cycles.
module pcm_strobe_port #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              strobe_in,
    input  logic              din_in,
    input  logic [WORD_W-1:0] tx_byte,
    input  logic              tx_load,
    output logic              pcm_dout,
    output logic              pcm_dout_oe,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int N_SYNC = 3;

    logic [N_SYNC-1:0] pins_s;
    logic              bclk_s;
    logic              strobe_s;
    logic              din_s;
    logic              bit_rise;
    logic              bit_fall;
    logic              slot_open;

    pcm_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bclk_in, strobe_in, din_in}),
        .sync_out (pins_s)
    );

    assign {bclk_s, strobe_s, din_s} = pins_s;

    pcm_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (bclk_s),
        .rise  (bit_rise),
        .fall  (bit_fall)
    );

    pcm_tx_shift #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_rise  (bit_rise),
        .strobe    (strobe_s),
        .load_byte (tx_byte),
        .load_en   (tx_load),
        .ser_out   (pcm_dout),
        .slot_open (slot_open)
    );

    pcm_rx_shift #(.WORD_W(WORD_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_fall   (bit_fall),
        .slot_open  (slot_open),
        .din        (din_s),
        .word_out   (rx_byte),
        .word_valid (rx_valid)
    );

    assign pcm_dout_oe = slot_open;

endmodule

// File: rtl/pcm_strobe_port_chk.sv
// Module: pcm_strobe_port_chk
// Property checker for pcm_strobe_port, attached by bind below.
// Assumes: it sees the synchronised strobe and rising-edge pulse of the port.
module pcm_strobe_port_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_rise,
    input logic              strobe_s,
    input logic              dout,
    input logic              dout_oe,
    input logic [WORD_W-1:0] rx_byte,
    input logic              rx_valid
);

    // R2: the slot opens only on a rising edge that sees the strobe high.
    assert_oe_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(bit_rise && strobe_s));

    // R2: the slot closes only on a rising edge that sees the strobe low.
    assert_oe_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_oe) |-> $past(bit_rise && !strobe_s));

    // R2: output is quiet while not driven.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

    // R3: serial output changes only after a rising edge.
    assert_dout_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(bit_rise));

    // R6: valid is a single-cycle pulse.
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6: a word completes only while the slot was open.
    assert_valid_in_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(dout_oe));

    // R7: the received byte changes only together with valid.
    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_valid);

endmodule

bind pcm_strobe_port pcm_strobe_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_rise (bit_rise),
    .strobe_s (strobe_s),
    .dout     (pcm_dout),
    .dout_oe  (pcm_dout_oe),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid)
);

// File: tb/tb_pcm_strobe_port.sv
// Directed bench for pcm_strobe_port: one task per scenario.
module tb_pcm_strobe_port;

    localparam int W    = 8;
    localparam int HALF = 8;   // system cycles per bit-clock phase

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk_in = 1'b0;
    logic         strobe_in = 1'b0;
    logic         din_in = 1'b0;
    logic [W-1:0] tx_byte = '0;
    logic         tx_load = 1'b0;
    logic         pcm_dout;
    logic         pcm_dout_oe;
    logic [W-1:0] rx_byte;
    logic         rx_valid;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int wide   = 0;
    logic valid_d = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pcm_strobe_port dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_in     (bclk_in),
        .strobe_in   (strobe_in),
        .din_in      (din_in),
        .tx_byte     (tx_byte),
        .tx_load     (tx_load),
        .pcm_dout    (pcm_dout),
        .pcm_dout_oe (pcm_dout_oe),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid)
    );

    // Count valid pulses and any pulse wider than one cycle.
    always @(posedge clk) begin
        if (rx_valid) pulses <= pulses + 1;
        if (rx_valid && valid_d) wide <= wide + 1;
        valid_d <= rx_valid;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load_tx(input logic [W-1:0] b);
        @(negedge clk);
        tx_byte = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // One frame: nbits strobed bits; optional write in the middle of the slot.
    task automatic run_frame(input logic [W-1:0] exp_tx, input logic [W-1:0] rx_in,
                             input int nbits, input bit mid_en,
                             input logic [W-1:0] mid_byte, input string tag);
        logic [15:0] seen = '0;
        int oe_bad = 0;
        int p0 = pulses;
        int w0 = wide;
        logic [W-1:0] prev_rx = rx_byte;
        logic [15:0] want = '0;
        @(negedge clk);
        strobe_in = 1'b1;
        wait_cycles(HALF);
        for (int i = 0; i < nbits; i++) begin
            bclk_in = 1'b1;
            din_in  = (i < W) ? rx_in[W-1-i] : 1'b1;
            if (mid_en && i == 3) begin
                tx_byte = mid_byte;
                tx_load = 1'b1;
                @(negedge clk);
                tx_load = 1'b0;
                wait_cycles(HALF - 1);
            end else begin
                wait_cycles(HALF);
            end
            seen[15-i] = pcm_dout;
            if (pcm_dout_oe !== 1'b1) oe_bad++;
            if (i < W) want[15-i] = exp_tx[W-1-i];
            bclk_in = 1'b0;
            if (i == nbits - 1) strobe_in = 1'b0;
            wait_cycles(HALF);
        end
        bclk_in = 1'b1;
        wait_cycles(HALF);
        check({"R2 oe high in slot ", tag}, oe_bad, 0);
        check({"R2 oe low after slot ", tag}, int'(pcm_dout_oe), 0);
        check({"R2 dout quiet after slot ", tag}, int'(pcm_dout), 0);
        check({"R3 R4 R8 serial bits MSB first ", tag}, int'(seen), int'(want));
        bclk_in = 1'b0;
        wait_cycles(HALF);
        if (nbits >= W) begin
            check({"R6 R8 one valid pulse ", tag}, pulses - p0, 1);
            check({"R5 received byte ", tag}, int'(rx_byte), int'(rx_in));
        end else begin
            check({"R7 no pulse on short slot ", tag}, pulses - p0, 0);
            check({"R7 byte kept on short slot ", tag}, int'(rx_byte), int'(prev_rx));
        end
        check({"R6 pulse width one ", tag}, wide - w0, 0);
    endtask

    task automatic test_reset();
        check("R1 oe after reset", int'(pcm_dout_oe), 0);
        check("R1 dout after reset", int'(pcm_dout), 0);
        check("R1 valid after reset", int'(rx_valid), 0);
        check("R1 rx_byte after reset", int'(rx_byte), 0);
    endtask

    task automatic test_patterns();
        load_tx(8'hA5); run_frame(8'hA5, 8'h3C, 8, 1'b0, '0, "pat A5");
        load_tx(8'hFF); run_frame(8'hFF, 8'h00, 8, 1'b0, '0, "pat FF");
        load_tx(8'h00); run_frame(8'h00, 8'hFF, 8, 1'b0, '0, "pat 00");
        load_tx(8'h81); run_frame(8'h81, 8'h96, 8, 1'b0, '0, "pat 81");
    endtask

    task automatic test_mid_load_R4();
        load_tx(8'h5A);
        run_frame(8'h5A, 8'h11, 8, 1'b1, 8'hC3, "R4 mid write frame");
        run_frame(8'hC3, 8'h22, 8, 1'b0, '0, "R4 next frame");
    endtask

    task automatic test_short_R7();
        load_tx(8'h77);
        run_frame(8'h70, 8'hE8, 5, 1'b0, '0, "R7 short");
        run_frame(8'h77, 8'h4B, 8, 1'b0, '0, "R7 after short");
    endtask

    task automatic test_long_R8();
        load_tx(8'hB2);
        run_frame(8'hB2, 8'h6D, 11, 1'b0, '0, "R8 long");
    endtask

    initial begin
        wait_cycles(5);
        rst_n = 1'b1;
        wait_cycles(2);
        test_reset();
        test_patterns();
        test_mid_load_R4();
        test_short_R7();
        test_long_R8();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule